// File: doc/BRIEF.md
# Receive Partial Checksum Engine

This block watches the byte stream that an Ethernet receive MAC delivers and computes a 16-bit ones-complement sum over the tail of each frame. Summing starts at a programmable offset, given in 16-bit half-words, and runs through the last byte of the frame. Bytes are paired big-endian from the start of the frame. Software later subtracts or adds header fields itself to turn this partial sum into a full TCP or UDP checksum check.

When the last byte of a frame is accepted, the block packs a 32-bit receive status word. The word holds the inverted sum, the frame length in bytes, a sticky overflow flag and a cleared ownership bit, which hands the descriptor back to software. The word is presented with a one-cycle write strobe to whatever stores descriptors. For untagged IPv4 the usual offset is 17 half-words, which skips the 14-byte link header and the 20-byte base IP header. A VLAN tag moves it to 19.

Top module: `rx_partial_csum`

## Requirements
- R1: After reset, descWe is 0 and descWord is 0.
- R2: The sum covers byte offsets 2*S through the last byte, where S is cfgStart (half-words) and offset 0 is the first byte of the frame. Bytes before 2*S are excluded. Byte at even offset k and byte k+1 form the 16-bit word {byte k, byte k+1}.
- R3: A final byte at an even offset, which has no partner, is summed as {byte, 8'h00}.
- R4: Carries out of bit 15 are folded back in end-around until the sum fits in 16 bits. An all-0xFF window sums to 0xFFFF.
- R5: descWord[15:0] is the bitwise inverse of the folded sum. A frame that ends before offset 2*S reports 16'hFFFF.
- R6: descWord[29:16] is the number of bytes accepted in the frame, including the last.
- R7: descWord[30] is 1 when ovfIn was high on any accepted byte of the frame. ovfIn in idle cycles is ignored, and the flag does not carry into the next frame.
- R8: descWord[31] (ownership) is 0 in every status word written.
- R9: descWe is high for exactly one cycle, in the cycle after the last byte (inValid and inLast) is accepted. descWord holds its value until the next strobe.
- R10: cfgStart is sampled with the first byte of a frame. Changes later in the same frame have no effect on that frame.
- R11: Cycles with inValid low accept nothing. inData, inLast and ovfIn are ignored in those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A byte is presented this cycle |
| inData | input | 8 | Received byte |
| inLast | input | 1 | This byte ends the frame |
| ovfIn | input | 1 | Receive buffer overflow seen with this byte |
| cfgStart | input | 7 | Sum start offset in 16-bit half-words |
| descWord | output | 32 | Receive status word {own, overflow, length, inverted sum} |
| descWe | output | 1 | One-cycle write strobe for descWord |

## Verification
The hardest situation to reach from the ports is a frame whose window ends on an unpaired even-offset byte while the offset itself is being rewritten and bubbles are interleaved. That combination exercises the pad, the latched offset and the gap filter at once. The stimulus reaches it with a directed frame that changes cfgStart after the first byte and inserts idle cycles carrying a noisy inLast, ovfIn and data. It also uses table frames whose lengths end one byte past the start offset, and a window full of 0xFF bytes that forces a carry on every add.

// File: rtl/rxcs_pkg.sv
package rxcs_pkg;
  localparam int LEN_W   = 14;  // frame length field width
  localparam int OFS_W   = 7;   // start offset width (half-words)
  localparam int BYTE_W  = 8;
  localparam int SUM_W   = 2 * BYTE_W;
  localparam int WORD_W  = 32;
  localparam int LEN_LSB = SUM_W;
  localparam int OVF_BIT = LEN_LSB + LEN_W;
  localparam int OWN_BIT = OVF_BIT + 1;

  typedef struct packed {
    logic             clear;    // first byte of a frame accepted
    logic             takeHi;   // store byte as high half of a pair
    logic             addPair;  // add {hi, byte}
    logic             addTail;  // add {byte, 0}
    logic             finish;   // last byte accepted
    logic             ovf;      // overflow seen in this frame so far
    logic [LEN_W-1:0] len;      // byte count including this byte
  } ctl_t;
endpackage

// File: rtl/rxcs_ctrl.sv
module rxcs_ctrl
  import rxcs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inLast,
  input  logic             ovfIn,
  input  logic [OFS_W-1:0] cfgStart,
  output ctl_t             ctl
);
  logic             inFrame;
  logic [LEN_W-1:0] byteCnt;
  logic [OFS_W-1:0] startLat;
  logic             ovfSticky;

  logic             firstByte;
  logic [OFS_W-1:0] curStart;
  logic [LEN_W-1:0] startByte;
  logic             inWindow;
  logic             evenPos;
  logic             ovfNext;

  always_comb begin
    firstByte = !inFrame;
    curStart  = firstByte ? cfgStart : startLat;
    startByte = LEN_W'({curStart, 1'b0});
    inWindow  = byteCnt >= startByte;
    evenPos   = !byteCnt[0];
    ovfNext   = (firstByte ? 1'b0 : ovfSticky) | ovfIn;

    ctl.clear   = inValid && firstByte;
    ctl.takeHi  = inValid && evenPos;
    ctl.addPair = inValid && !evenPos && inWindow;
    ctl.addTail = inValid && evenPos && inLast && inWindow;
    ctl.finish  = inValid && inLast;
    ctl.ovf     = ovfNext;
    ctl.len     = byteCnt + LEN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame   <= 1'b0;
      byteCnt   <= '0;
      startLat  <= '0;
      ovfSticky <= 1'b0;
    end else if (inValid) begin
      if (inLast) begin
        inFrame   <= 1'b0;
        byteCnt   <= '0;
        ovfSticky <= 1'b0;
      end else begin
        inFrame   <= 1'b1;
        byteCnt   <= byteCnt + LEN_W'(1);
        ovfSticky <= ovfNext;
        if (firstByte) startLat <= cfgStart;
      end
    end
  end
endmodule

// File: rtl/rxcs_datapath.sv
module rxcs_datapath
  import rxcs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] inData,
  input  ctl_t              ctl,
  output logic [WORD_W-1:0] descWord,
  output logic              descWe
);
  logic [BYTE_W-1:0] hiByte;
  logic [SUM_W-1:0]  sumAcc;
  logic [SUM_W-1:0]  sumBase;
  logic [SUM_W-1:0]  addend;
  logic [SUM_W:0]    rawSum;
  logic [SUM_W-1:0]  foldSum;

  always_comb begin
    sumBase = ctl.clear ? '0 : sumAcc;
    if (ctl.addPair)      addend = {hiByte, inData};
    else if (ctl.addTail) addend = {inData, {BYTE_W{1'b0}}};
    else                  addend = '0;
    rawSum  = {1'b0, sumBase} + {1'b0, addend};
    // one end-around fold suffices: rawSum <= 2*(2^16-1)
    foldSum = rawSum[SUM_W-1:0] + {{(SUM_W-1){1'b0}}, rawSum[SUM_W]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiByte   <= '0;
      sumAcc   <= '0;
      descWord <= '0;
      descWe   <= 1'b0;
    end else begin
      if (ctl.takeHi) hiByte <= inData;
      if (ctl.clear || ctl.addPair || ctl.addTail) sumAcc <= foldSum;
      descWe <= ctl.finish;
      if (ctl.finish) begin
        descWord[OWN_BIT]               <= 1'b0;
        descWord[OVF_BIT]               <= ctl.ovf;
        descWord[OVF_BIT-1:LEN_LSB]     <= ctl.len;
        descWord[SUM_W-1:0]             <= ~foldSum;
      end
    end
  end
endmodule

// File: rtl/rx_partial_csum.sv
module rx_partial_csum
  import rxcs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inLast,
  input  logic              ovfIn,
  input  logic [OFS_W-1:0]  cfgStart,
  output logic [WORD_W-1:0] descWord,
  output logic              descWe
);
  ctl_t ctl;

  rxcs_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inLast   (inLast),
    .ovfIn    (ovfIn),
    .cfgStart (cfgStart),
    .ctl      (ctl)
  );

  rxcs_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inData   (inData),
    .ctl      (ctl),
    .descWord (descWord),
    .descWe   (descWe)
  );
endmodule

// File: rtl/rxcs_checker.sv
module rxcs_checker
  import rxcs_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inLast,
  input logic              ovfIn,
  input logic [WORD_W-1:0] descWord,
  input logic              descWe
);
  assert_strobe_after_last_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inLast) |=> descWe);

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inLast) |=> !descWe);

  assert_word_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    !descWe |-> $stable(descWord));

  assert_owner_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    descWe |-> !descWord[OWN_BIT]);

  assert_ovf_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inLast && ovfIn) |=> descWord[OVF_BIT]);
endmodule

bind rx_partial_csum rxcs_checker u_chk (.*);

// File: tb/tb_rx_partial_csum.sv
`timescale 1ns/1ps
module tb_rx_partial_csum;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inData = 8'h00;
  logic        inLast = 1'b0;
  logic        ovfIn = 1'b0;
  logic [6:0]  cfgStart = 7'd0;
  logic [31:0] descWord;
  logic        descWe;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  rx_partial_csum dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inLast(inLast), .ovfIn(ovfIn), .cfgStart(cfgStart),
    .descWord(descWord), .descWe(descWe)
  );

  typedef struct packed {
    logic [1:0]  kind;   // 0 pattern, 1 all 0xFF, 2 all 0x80
    logic [13:0] len;
    logic [6:0]  start;
    logic [7:0]  seed;
    logic        ovfEn;
    logic [13:0] ovfAt;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 14'd60,  7'd17,  8'h11, 1'b0, 14'd0},   // R2 even length
    '{2'd0, 14'd61,  7'd17,  8'h22, 1'b0, 14'd0},   // R3 odd tail
    '{2'd0, 14'd64,  7'd19,  8'h33, 1'b0, 14'd0},   // R2 tagged offset
    '{2'd0, 14'd1,   7'd0,   8'h44, 1'b0, 14'd0},   // R3 single byte
    '{2'd0, 14'd10,  7'd17,  8'h55, 1'b0, 14'd0},   // R5 ends before start
    '{2'd1, 14'd100, 7'd0,   8'h00, 1'b0, 14'd0},   // R4 all 0xFF
    '{2'd2, 14'd90,  7'd3,   8'h00, 1'b0, 14'd0},   // R4 carry chain
    '{2'd0, 14'd300, 7'd127, 8'h77, 1'b0, 14'd0},   // R2 max offset
    '{2'd0, 14'd35,  7'd17,  8'h99, 1'b0, 14'd0},   // R3 tail only
    '{2'd0, 14'd40,  7'd5,   8'h88, 1'b1, 14'd7},   // R7 overflow
    '{2'd0, 14'd40,  7'd5,   8'h89, 1'b0, 14'd0}    // R7 cleared next frame
  };

  function automatic logic [7:0] genByte(vec_t v, int i);
    case (v.kind)
      2'd1:    return 8'hFF;
      2'd2:    return 8'h80;
      default: return 8'(int'(v.seed) + i * 37 + (i >> 4));
    endcase
  endfunction

  function automatic logic [31:0] expWord(vec_t v);
    logic [31:0] acc = 32'd0;
    for (int i = 2 * int'(v.start); i < int'(v.len); i++) begin
      if (i % 2 == 0) acc += {16'd0, genByte(v, i), 8'd0};
      else            acc += {24'd0, genByte(v, i)};
    end
    while (acc[31:16] != 16'd0) acc = {16'd0, acc[15:0]} + {16'd0, acc[31:16]};
    return {1'b0, v.ovfEn && (v.ovfAt < v.len), v.len, ~acc[15:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] lastExp;

  task automatic sendFrame(vec_t v, string tag, bit gaps, bit cfgChange);
    for (int i = 0; i < int'(v.len); i++) begin
      @(negedge clk);
      inValid  = 1'b1;
      inData   = genByte(v, i);
      inLast   = (i == int'(v.len) - 1);
      ovfIn    = v.ovfEn && (i == int'(v.ovfAt));
      cfgStart = (cfgChange && i > 0) ? ~v.start : v.start;
      if (gaps && (i % 3 == 2) && !inLast) begin
        @(negedge clk);
        inValid = 1'b0;     // R11 noise in idle cycle
        inData  = 8'hA5;
        inLast  = 1'b1;
        ovfIn   = 1'b1;
      end
    end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0; ovfIn = 1'b0;
    lastExp = expWord(v);
    chk({tag, " R9 strobe"}, {31'd0, descWe}, 32'd1);
    chk({tag, " word"}, descWord, lastExp);
    @(negedge clk);
    chk({tag, " R9 single pulse"}, {31'd0, descWe}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset strobe", {31'd0, descWe}, 32'd0);
    chk("R1 reset word", descWord, 32'd0);
    rstN = 1'b1;

    for (int k = 0; k < NV; k++) begin
      sendFrame(VECS[k], $sformatf("vec%0d R2 R3 R4 R5 R6 R7 R8", k), 1'b0, 1'b0);
    end

    // R11: bubbles carrying noisy inLast/ovfIn/data
    sendFrame('{2'd0, 14'd50, 7'd2, 8'h3C, 1'b0, 14'd0}, "R11 gaps", 1'b1, 1'b0);

    // R10: offset rewritten after the first byte
    sendFrame('{2'd0, 14'd45, 7'd4, 8'h5E, 1'b0, 14'd0}, "R10 cfg change", 1'b0, 1'b1);

    // R10 + R11 + R3 together
    sendFrame('{2'd0, 14'd39, 7'd17, 8'h61, 1'b0, 14'd0}, "R10 R11 R3 combo", 1'b1, 1'b1);

    // R9: word holds across idle cycles with noisy inputs
    repeat (5) begin
      @(negedge clk);
      inData = 8'hC3; ovfIn = 1'b1; inLast = 1'b1; cfgStart = 7'd9;
    end
    @(negedge clk);
    inLast = 1'b0; ovfIn = 1'b0;
    chk("R9 hold word", descWord, lastExp);
    chk("R9 hold strobe", {31'd0, descWe}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule